// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block turns a fast converter clock into a one-cycle clock enable at an integer fraction of that clock's rate. A register selects one of two input paths. On the normal path the main divider counts input cycles directly. On the high-frequency path a fixed divide-by-4 prescaler runs first, so the main divider counts prescaler ticks. The main divider ratio can be any integer from 1 to 8. Whenever the ratio is not 1, the block also drives a flag that switches on the downstream duty-cycle stage.

A system reference pulse (SYSREF) can put the prescaler and the divider back at their starting phase. Several instances that see the same reference edge then produce their enables in lockstep. The reference can realign the divider on every rising edge. It can also realign only once per write to the sync register, or be ignored entirely.

The block carries no data stream, so it has no valid/ready handshake. The register port, the reference input and both outputs are plain control pins. Writes take effect at the next clock edge, and read data is combinational from the address. Everything runs in one clock domain, the input clock.

Top module: `sync_clk_divider`

## Requirements
- R1: Register 0x0B bits [2:0] hold the divide ratio minus one (0 means divide by 1, 7 means divide by 8). With the normal input, `div_ce` pulses once every N clock cycles in steady state.
- R2: Writing register 0x09 bit 0 to 1 selects the high-frequency path with the divide-by-4 prescaler, and the pulse period becomes 4·N cycles. Writing it to 0 returns to the normal path.
- R3: A newly written ratio is taken up only when the current count wraps, so the period already in progress completes with the old ratio.
- R4: `dcs_en` is high exactly when the stored ratio field is nonzero, starting from the clock edge that stores the write.
- R5: `div_ce` is high for one cycle per period. With ratio 1 on the normal input it is high on every cycle.
- R6: Register 0x3A bit 1 enables sync and bit 2 chooses first-only mode. In every-edge mode, each rising edge of `sysref` restarts the divider. After a restart, `div_ce` is high in the cycle that begins P·N clock edges after the first edge that samples `sysref` high. P is 4 on the high-frequency path and 1 otherwise.
- R7: A `sysref` level held high causes only one restart. A new rising edge is needed for the next one.
- R8: In first-only mode, any write to 0x3A arms the sync. The first rising edge after the write restarts the divider and disarms it. Later edges leave `div_ce` unchanged until 0x3A is written again.
- R9: With 0x3A bit 1 clear, `sysref` has no effect on `div_ce`, whatever bit 2 holds.
- R10: After reset all three registers read 0: divide by 1, normal input, sync off. Reads return only the defined bits, with other bits 0. Writes to any other address change nothing, and reading any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input converter clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref | input | 1 | Reference pulse used to realign the divider phase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the register at `reg_addr` |
| div_ce | output | 1 | Divided clock enable, one cycle per period |
| dcs_en | output | 1 | Duty-cycle stage enable, high when the ratio is not 1 |

## Verification
A register write shows on `reg_rdata` and `dcs_en` one edge after the strobe is sampled. `div_ce` is a combinational decode of counter state, so any change to it appears in the cycle after the edge that updated that state. A reference edge restarts the counters two edges after `sysref` rises: one edge samples it and the next acts on it. The bench keeps a behavioural per-cycle model that follows this timing. It drives inputs 1 ns after each rising edge and compares every output at the falling edge. Directed checks also count falling edges between pulses for the period checks, and from the raising of `sysref` for alignment (P·N+2 falling edges).

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int REG_AW  = 8;
  localparam int REG_DW  = 8;
  localparam int RATIO_W = 3;
  localparam int PRE_W   = 2;

  localparam logic [REG_AW-1:0] ADDR_INSEL = 8'h09;
  localparam logic [REG_AW-1:0] ADDR_RATIO = 8'h0B;
  localparam logic [REG_AW-1:0] ADDR_SYNC  = 8'h3A;

  typedef struct packed {
    logic               hf_sel;
    logic [RATIO_W-1:0] ratio_m1;
    logic               sync_en;
    logic               sync_once;
  } cdiv_cfg_t;
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output cdiv_cfg_t         cfg,
  output logic              sync_wr
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[REG_DW-1:RATIO_W];

  assign sync_wr = wr && (addr == ADDR_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_INSEL: cfg.hf_sel   <= wdata[0];
        ADDR_RATIO: cfg.ratio_m1 <= wdata[RATIO_W-1:0];
        ADDR_SYNC: begin
          cfg.sync_en   <= wdata[1];
          cfg.sync_once <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_INSEL: rdata[0] = cfg.hf_sel;
      ADDR_RATIO: rdata[RATIO_W-1:0] = cfg.ratio_m1;
      ADDR_SYNC: begin
        rdata[1] = cfg.sync_en;
        rdata[2] = cfg.sync_once;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdiv_sync.sv
module cdiv_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref,
  input  logic sync_en,
  input  logic sync_once,
  input  logic sync_wr,
  output logic fire,
  output logic armed
);
  logic ref_q1, ref_q2, ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q1 <= 1'b0;
      ref_q2 <= 1'b0;
    end else begin
      ref_q1 <= sysref;
      ref_q2 <= ref_q1;
    end
  end

  assign ref_rise = ref_q1 & ~ref_q2;
  assign fire     = ref_rise & sync_en & (~sync_once | armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed <= 1'b0;
    else if (sync_wr)           armed <= 1'b1;
    else if (fire && sync_once) armed <= 1'b0;
  end
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter
  import cdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hf_sel,
  input  logic [RATIO_W-1:0] ratio_m1,
  input  logic               restart,
  output logic               ce,
  output logic [RATIO_W-1:0] cnt,
  output logic [PRE_W-1:0]   pre
);
  logic [RATIO_W-1:0] active_m1;
  logic tick, at_end;

  assign tick   = ~hf_sel | (pre == {PRE_W{1'b1}});
  assign at_end = (cnt == active_m1);
  assign ce     = tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (restart || !hf_sel) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active_m1 <= '0;
    end else if (restart) begin
      cnt       <= '0;
      active_m1 <= ratio_m1;
    end else if (tick) begin
      if (at_end) begin
        cnt       <= '0;
        active_m1 <= ratio_m1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysref,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              div_ce,
  output logic              dcs_en
);
  cdiv_cfg_t          cfg;
  logic               sync_wr, sync_fire, sync_armed;
  logic [RATIO_W-1:0] div_cnt;
  logic [PRE_W-1:0]   pre_cnt;

  cdiv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .sync_wr(sync_wr)
  );

  cdiv_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sysref(sysref), .sync_en(cfg.sync_en),
    .sync_once(cfg.sync_once), .sync_wr(sync_wr), .fire(sync_fire),
    .armed(sync_armed)
  );

  cdiv_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .hf_sel(cfg.hf_sel), .ratio_m1(cfg.ratio_m1),
    .restart(sync_fire), .ce(div_ce), .cnt(div_cnt), .pre(pre_cnt)
  );

  assign dcs_en = |cfg.ratio_m1;
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker
  import cdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [REG_DW-1:0]  reg_wdata,
  input logic [REG_DW-1:0]  reg_rdata,
  input logic               div_ce,
  input logic               dcs_en,
  input logic               hf_sel,
  input logic               sync_fire,
  input logic               sync_once,
  input logic               armed,
  input logic [RATIO_W-1:0] cnt,
  input logic [PRE_W-1:0]   pre
);
  AST_DCS_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_RATIO) |=> (dcs_en == ($past(reg_wdata[RATIO_W-1:0]) != '0))); // R4

  AST_HF_NO_ADJACENT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_sel && $past(hf_sel) && div_ce) |-> !$past(div_ce)); // R2

  AST_CE_THEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    div_ce |=> (cnt == '0)); // R5

  AST_SYNC_ZEROES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |=> (cnt == '0 && pre == '0)); // R6

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire |=> !sync_fire); // R7

  AST_ONESHOT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fire && sync_once && !(reg_wr && reg_addr == ADDR_SYNC)) |=> !armed); // R8

  AST_RATIO_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_RATIO) |-> (reg_rdata[REG_DW-1:RATIO_W] == '0)); // R10
endmodule

bind sync_clk_divider cdiv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_ce(div_ce),
  .dcs_en(dcs_en), .hf_sel(cfg.hf_sel), .sync_fire(sync_fire),
  .sync_once(cfg.sync_once), .armed(sync_armed), .cnt(div_cnt), .pre(pre_cnt)
);

// File: tb/sync_clk_divider_test.sv
module sync_clk_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, sysref = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire        div_ce, dcs_en;

  always #2 clk = ~clk;

  sync_clk_divider uut (
    .clk(clk), .rst_n(rst_n), .sysref(sysref), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_ce(div_ce), .dcs_en(dcs_en)
  );

  int checks = 0, errors = 0, wd = 0;
  bit done = 1'b0;
  string tag = "R10";

  int m_sel, m_ratio, m_en, m_once, m_armed, m_pre, m_cnt, m_act, m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_ratio = 0; m_en = 0; m_once = 0; m_armed = 0;
      m_pre = 0; m_cnt = 0; m_act = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit fire, tick;
      fire = (m_s1 == 1 && m_s2 == 0) && m_en == 1 && (m_once == 0 || m_armed == 1);
      tick = (m_sel == 0) || (m_pre == 3);
      if (reg_wr && reg_addr == 8'h3A) m_armed = 1;
      else if (fire && m_once == 1) m_armed = 0;
      if (fire) begin
        m_pre = 0; m_cnt = 0; m_act = m_ratio;
      end else begin
        m_pre = (m_sel == 1) ? (m_pre + 1) % 4 : 0;
        if (tick) begin
          if (m_cnt == m_act) begin m_cnt = 0; m_act = m_ratio; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (reg_wr) begin
        if (reg_addr == 8'h09) m_sel = int'(reg_wdata[0]);
        if (reg_addr == 8'h0B) m_ratio = int'(reg_wdata[2:0]);
        if (reg_addr == 8'h3A) begin m_en = int'(reg_wdata[1]); m_once = int'(reg_wdata[2]); end
      end
      m_s2 = m_s1;
      m_s1 = int'(sysref);
    end
  end

  function automatic int exp_rdata(input logic [7:0] a);
    if (a == 8'h09) return m_sel;
    if (a == 8'h0B) return m_ratio;
    if (a == 8'h3A) return m_once * 4 + m_en * 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_ce;
      e_ce = (((m_sel == 0) || (m_pre == 3)) && m_cnt == m_act) ? 1 : 0;
      chk(int'(div_ce) == e_ce, tag, int'(div_ce), e_ce);
      chk(int'(dcs_en) == ((m_ratio != 0) ? 1 : 0), "R4", int'(dcs_en), (m_ratio != 0) ? 1 : 0);
      chk(int'(reg_rdata) == exp_rdata(reg_addr), "R10", int'(reg_rdata), exp_rdata(reg_addr));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", wd, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int len);
    @(posedge clk); #1; sysref = 1'b1;
    repeat (len) @(posedge clk);
    #1; sysref = 1'b0;
  endtask

  task automatic period(input int expv, input string t);
    int n;
    do @(negedge clk); while (!div_ce);
    n = 0;
    do begin @(negedge clk); n++; end while (!div_ce);
    chk(n == expv, t, n, expv);
  endtask

  task automatic align(input int expv, input string t);
    int k;
    @(posedge clk); #1; sysref = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!(div_ce && k >= 3));
    chk(k == expv, t, k, expv);
    #1; sysref = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(5);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    chk(dcs_en == 1'b0, "R4", int'(dcs_en), 0);
    #1; reg_addr = 8'h3A; @(negedge clk);
    chk(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    #1; reg_addr = 8'h00;

    tag = "R5";
    period(1, "R5");
    idle(5);

    tag = "R1";
    wr(8'h0B, 8'h01); period(2, "R1"); period(2, "R1");
    chk(dcs_en == 1'b1, "R4", int'(dcs_en), 1);
    wr(8'h0B, 8'h04); period(5, "R1"); period(5, "R1");
    wr(8'h0B, 8'h07); period(8, "R1"); period(8, "R1");

    tag = "R3";
    idle(3);
    wr(8'h0B, 8'h02);
    idle(20);
    period(3, "R3");

    tag = "R2";
    wr(8'h09, 8'h01);
    wr(8'h0B, 8'h01); period(8, "R2"); period(8, "R2");
    wr(8'h0B, 8'h00); period(4, "R2"); period(4, "R2");
    wr(8'h09, 8'h00); period(1, "R2");

    tag = "R6";
    wr(8'h3A, 8'h02);
    wr(8'h0B, 8'h04);
    idle(7);
    align(7, "R6");
    idle(2);
    align(7, "R6");
    wr(8'h09, 8'h01);
    wr(8'h0B, 8'h02);
    idle(5);
    align(14, "R6");

    tag = "R7";
    wr(8'h09, 8'h00);
    wr(8'h0B, 8'h05);
    idle(4);
    pulse(30);
    idle(10);

    tag = "R8";
    wr(8'h3A, 8'h06);
    idle(3);
    pulse(2); idle(4);
    pulse(3); idle(7);
    pulse(1); idle(9);
    wr(8'h3A, 8'h06);
    idle(2);
    pulse(2); idle(5);
    pulse(2); idle(12);

    tag = "R9";
    wr(8'h3A, 8'h00);
    pulse(2); idle(3); pulse(4); idle(10);
    wr(8'h3A, 8'h04);
    pulse(2); idle(5); pulse(1); idle(10);

    tag = "R10";
    wr(8'h10, 8'hFF);
    #0 reg_addr = 8'h10; @(negedge clk);
    chk(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    #1;
    wr(8'h0B, 8'hFD);
    #0 reg_addr = 8'h0B; @(negedge clk);
    chk(reg_rdata == 8'h05, "R10", int'(reg_rdata), 5);
    #1;
    wr(8'h09, 8'hFE);
    #0 reg_addr = 8'h09; @(negedge clk);
    chk(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    #1; reg_addr = 8'h00;
    idle(20);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule